// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counter of a multi-channel interval timer. It advances on every rising edge of its count clock once a count has been loaded. A load strobe presents a new initial value together with a 3-bit operating mode. The block then drives a single output line whose waveform depends on the mode: a terminal-count flag, a retriggerable one-shot, a periodic rate pulse, a square wave, or a one-clock strobe. The live count value is exposed so that a neighbouring host-interface block can latch it.

A gate input qualifies counting, and its meaning depends on the mode. In some modes its level pauses the count. In others its rising edge restarts the count from the programmed value. Mode encodings 6 and 7 behave as 2 and 3. Control-word decoding, host read/write sequencing and read-back are handled by the surrounding timer.

Top module: `ivt_channel`

## Requirements
- R1: A loaded value of 0 acts as a count of 65536. In mode 0, OUT rises exactly 65536 clocks after the load edge.
- R2: On the clock edge where `load_i` is high, the count takes `load_val_i`. Each following enabled clock lowers it by one (modes 0, 1, 4, 5), and it wraps from 0 to 0xFFFF.
- R3: Mode 0 (`mode_i` = 3'd0): OUT goes low at the load edge. It goes high on the edge where the count reaches 0 and stays high while the count keeps wrapping, until the next load.
- R4: In modes 0, 2, 3 and 4, a low gate holds the count. In modes 0 and 4, a gate rising edge resumes counting without any reload.
- R5: Mode 1 (`mode_i` = 3'd1): OUT goes low at the load edge and at each gate rising edge. A gate rising edge reloads the programmed count. OUT goes high when the count reaches 0. The gate level does not pause counting.
- R6: Mode 2 (`mode_i` = 3'd2, N ≥ 2): the period is N clocks. OUT is low for exactly the one clock in which the count is 1. On the next edge the count reloads N and OUT returns high.
- R7: Mode 3 (`mode_i` = 3'd3, N ≥ 2): the count steps by two per clock. For even N, OUT is high for N/2 clocks and low for N/2 clocks. For odd N, it is high for (N+1)/2 clocks and low for (N−1)/2 clocks.
- R8: Mode 4 (`mode_i` = 3'd4): OUT stays high except for one clock when the count first reaches 0 after a load. It does not pulse again when the count later wraps to 0.
- R9: Mode 5 (`mode_i` = 3'd5): a gate rising edge reloads the programmed count. OUT pulses low for one clock when the count reaches 0.
- R10: In modes 2 and 3, a low gate forces OUT high on the next edge and halts the count. A gate rising edge restarts from the programmed count with OUT high.
- R11: After reset, OUT is high and the count is 0. The count does not change until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Gate: level enable or edge trigger, depending on mode |
| load_i | input | 1 | Load strobe; captures `load_val_i` and `mode_i` |
| load_val_i | input | 16 | Initial count; 0 means 65536 |
| mode_i | input | 3 | Operating mode 0..5 (6, 7 act as 2, 3) |
| out_o | output | 1 | Channel output line |
| count_o | output | 16 | Live count for external latching |

## Verification
The assertions assume that `load_i` is a single-clock strobe. They also assume that the gate, load and mode inputs are synchronous to the count clock. The periodic modes are assumed never to be loaded with a count of 1. The stimulus drives every input on the falling edge, loads periodic modes only with values of 2 or more, and resets between scenarios. This keeps each assertion's antecedent free of states from an earlier mode.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    MODE_TC_INT    = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } ivt_mode_e;

  typedef struct packed {
    logic tc_level;  // OUT low while counting, high after terminal count
    logic strobe;    // one-clock low pulse at terminal count
    logic rate;      // periodic, one-clock low pulse
    logic square;    // periodic, step by two
    logic gated;     // gate level pauses counting
    logic retrig;    // gate rising edge reloads
  } ivt_flags_t;

  // encodings 6 and 7 alias the periodic modes
  function automatic ivt_mode_e norm_mode(input logic [2:0] m);
    if (m[1]) return ivt_mode_e'({1'b0, m[1:0]});
    return ivt_mode_e'(m);
  endfunction

  function automatic ivt_flags_t decode_mode(input ivt_mode_e m);
    ivt_flags_t f;
    f = '0;
    case (m)
      MODE_TC_INT:    begin f.tc_level = 1'b1; f.gated = 1'b1; end
      MODE_ONESHOT:   begin f.tc_level = 1'b1; f.retrig = 1'b1; end
      MODE_RATE:      begin f.rate = 1'b1; f.gated = 1'b1; f.retrig = 1'b1; end
      MODE_SQUARE:    begin f.square = 1'b1; f.gated = 1'b1; f.retrig = 1'b1; end
      MODE_SW_STROBE: begin f.strobe = 1'b1; f.gated = 1'b1; end
      MODE_HW_STROBE: begin f.strobe = 1'b1; f.retrig = 1'b1; end
      default:        begin f.tc_level = 1'b1; f.gated = 1'b1; end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ivt_mode_ctrl.sv
module ivt_mode_ctrl
  import ivt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] mode_i,
  output logic       new_tc_level_o,
  output logic       new_square_o,
  output ivt_flags_t flags_o,
  output logic       armed_o
);
  ivt_mode_e mode_in;
  ivt_mode_e mode_q;
  logic      armed_q;

  assign mode_in        = norm_mode(mode_i);
  assign new_tc_level_o = (mode_in == MODE_TC_INT) || (mode_in == MODE_ONESHOT);
  assign new_square_o   = (mode_in == MODE_SQUARE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_TC_INT;
      armed_q <= 1'b0;
    end else if (load_i) begin
      mode_q  <= mode_in;
      armed_q <= 1'b1;
    end
  end

  assign flags_o = decode_mode(mode_q);
  assign armed_o = armed_q;

  AST_ARMED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q); // R11
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             new_square_i,
  input  logic             rate_i,
  input  logic             square_i,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic             out_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q, count_d, reload_q;

  // odd square-wave counts: high phase starts at N+1, low phase at N-1
  function automatic logic [CNT_W-1:0] phase_val(input logic [CNT_W-1:0] n,
                                                 input logic sq, input logic hi);
    if (sq && n[0]) return hi ? n + CNT_W'(1) : n - CNT_W'(1);
    return n;
  endfunction

  always_comb begin
    count_d = count_q;
    if (load_i) begin
      count_d = phase_val(load_val_i, new_square_i, 1'b1);
    end else if (restart_i) begin
      count_d = phase_val(reload_q, square_i, 1'b1);
    end else if (step_i) begin
      if (rate_i)
        count_d = (count_q == CNT_W'(1)) ? reload_q : count_q - CNT_W'(1);
      else if (square_i)
        count_d = (count_q == CNT_W'(2)) ? phase_val(reload_q, 1'b1, ~out_i)
                                         : count_q - CNT_W'(2);
      else
        count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      count_q <= count_d;
      if (load_i) reload_q <= load_val_i;
    end
  end

  assign count_o = count_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !new_square_i) |=> count_q == $past(load_val_i)); // R2
  AST_SQ_STEP_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (square_i && step_i && !load_i && !restart_i && count_q != CNT_W'(2))
      |=> count_q == $past(count_q) - CNT_W'(2)); // R7
endmodule

// File: rtl/ivt_out_gen.sv
module ivt_out_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             new_tc_level_i,
  input  logic             tc_level_i,
  input  logic             strobe_i,
  input  logic             rate_i,
  input  logic             square_i,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic             gate_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             out_o
);
  logic out_q, done_q;
  logic at_one;

  assign at_one = (count_i == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (load_i) begin
      out_q  <= ~new_tc_level_i;
      done_q <= 1'b0;
    end else if (restart_i) begin
      out_q  <= ~tc_level_i;
      done_q <= 1'b0;
    end else if ((rate_i || square_i) && !gate_i) begin
      out_q <= 1'b1;
    end else if (step_i) begin
      if (tc_level_i) begin
        if (at_one && !done_q) begin
          out_q  <= 1'b1;
          done_q <= 1'b1;
        end
      end else if (strobe_i) begin
        // pulse only on the first terminal count after a load
        out_q <= !(at_one && !done_q);
        if (at_one) done_q <= 1'b1;
      end else if (rate_i) begin
        out_q <= (count_i != CNT_W'(2));
      end else if (square_i) begin
        if (count_i == CNT_W'(2)) out_q <= ~out_q;
      end
    end
  end

  assign out_o = out_q;

  AST_TC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_level_i && out_q && !load_i && !restart_i) |=> out_q); // R3
  AST_RATE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i && !out_q && gate_i && !load_i) |=> out_q); // R6
  AST_STROBE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !out_q && step_i && !load_i && !restart_i) |=> out_q); // R8
  AST_GATE_FORCE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rate_i || square_i) && !gate_i && !load_i) |=> out_q); // R10
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [2:0]       mode_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  ivt_flags_t       flags;
  logic             new_tc_level, new_square, armed;
  logic             gate_rise, restart, step;
  logic [CNT_W-1:0] count;
  logic             out;

  ivt_mode_ctrl u_mode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (load_i),
    .mode_i         (mode_i),
    .new_tc_level_o (new_tc_level),
    .new_square_o   (new_square),
    .flags_o        (flags),
    .armed_o        (armed)
  );

  ivt_gate_edge u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  assign restart = armed & gate_rise & flags.retrig & ~load_i;
  assign step    = armed & (gate_i | ~flags.gated);

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .load_val_i   (load_val_i),
    .new_square_i (new_square),
    .rate_i       (flags.rate),
    .square_i     (flags.square),
    .restart_i    (restart),
    .step_i       (step),
    .out_i        (out),
    .count_o      (count)
  );

  ivt_out_gen #(.CNT_W(CNT_W)) u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (load_i),
    .new_tc_level_i (new_tc_level),
    .tc_level_i     (flags.tc_level),
    .strobe_i       (flags.strobe),
    .rate_i         (flags.rate),
    .square_i       (flags.square),
    .restart_i      (restart),
    .step_i         (step),
    .gate_i         (gate_i),
    .count_i        (count),
    .out_o          (out)
  );

  assign out_o   = out;
  assign count_o = count;

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && flags.gated && !gate_i && !load_i) |=> $stable(count_o)); // R4
  AST_IDLE_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !load_i) |=> $stable(count_o)); // R11
endmodule

// File: tb/ivt_channel_tb.sv
module ivt_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic        out;
  logic [15:0] count;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ivt_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .load_i(load),
    .load_val_i(load_val), .mode_i(mode), .out_o(out), .count_o(count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; load = 1'b0; gate = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    load = 1'b1; mode = m; load_val = v;
    step(1);
    load = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 out after reset", out, 1);
    chk("R11 count after reset", count, 0);
    gate = 1'b1;
    step(5);
    chk("R11 no count before load", count, 0);
  endtask

  task automatic t_mode0();
    do_reset(); gate = 1'b1;
    do_load(3'd0, 16'd5);
    chk("R2 count at load", count, 5);
    chk("R3 out low at load", out, 0);
    step(1); chk("R2 decrement", count, 4);
    step(3); chk("R3 out low at 1", out, 0);
    step(1); chk("R3 out high at 0", out, 1);
    step(1); chk("R2 wrap", count, 16'hFFFF);
    chk("R3 out stays high", out, 1);
  endtask

  task automatic t_zero();
    do_reset(); gate = 1'b1;
    do_load(3'd0, 16'd0);
    step(65535);
    chk("R1 count one before end", count, 1);
    chk("R1 out still low", out, 0);
    step(1); chk("R1 out high after 65536", out, 1);
  endtask

  task automatic t_gate_hold();
    do_reset(); gate = 1'b1;
    do_load(3'd0, 16'd10);
    step(2); chk("R4 counting", count, 8);
    gate = 1'b0; step(3); chk("R4 gate low holds", count, 8);
    gate = 1'b1; step(1); chk("R4 gate rise no reload", count, 7);
  endtask

  task automatic t_mode1();
    do_reset(); gate = 1'b0;
    do_load(3'd1, 16'd4);
    chk("R5 out low at load", out, 0);
    step(2); chk("R5 counts with gate low", count, 2);
    gate = 1'b1; step(1);
    chk("R5 gate rise reload", count, 4);
    chk("R5 out low after trigger", out, 0);
    step(3); chk("R5 out low at 1", out, 0);
    step(1); chk("R5 out high at 0", out, 1);
    gate = 1'b0; step(1); chk("R5 gate level ignored", count, 16'hFFFF);
  endtask

  task automatic t_mode2();
    int lows = 0;
    do_reset(); gate = 1'b1;
    do_load(3'd2, 16'd4);
    for (int i = 0; i < 12; i++) begin
      if (!out) lows++;
      if (i == 3) chk("R6 low at count 1", count, 1);
      if (i == 4) chk("R6 reload", count, 4);
      step(1);
    end
    chk("R6 one low clock per period", lows, 3);
    step(1); chk("R6 counting", count, 3);
    gate = 1'b0; step(2);
    chk("R10 mode2 hold", count, 3);
    chk("R10 mode2 out high", out, 1);
    gate = 1'b1; step(1);
    chk("R10 mode2 restart", count, 4);
  endtask

  task automatic t_mode3_even();
    int highs = 0;
    do_reset(); gate = 1'b1;
    do_load(3'd3, 16'd6);
    for (int i = 0; i < 12; i++) begin
      if (out) highs++;
      if (i == 1) chk("R7 step by two", count, 4);
      step(1);
    end
    chk("R7 even duty", highs, 6);
    step(4);
    chk("R7 low phase", out, 0);
    chk("R7 low phase count", count, 4);
    gate = 1'b0; step(1);
    chk("R10 mode3 forced high", out, 1);
    step(2); chk("R10 mode3 hold", count, 4);
    gate = 1'b1; step(1);
    chk("R10 mode3 restart", count, 6);
    chk("R10 mode3 restart high", out, 1);
  endtask

  task automatic t_mode3_odd();
    int highs = 0;
    do_reset(); gate = 1'b1;
    do_load(3'd3, 16'd5);
    for (int i = 0; i < 10; i++) begin
      if (out) highs++;
      step(1);
    end
    chk("R7 odd high longer", highs, 6);
    chk("R7 odd period", out, 1);
  endtask

  task automatic t_mode4();
    do_reset(); gate = 1'b1;
    do_load(3'd4, 16'd3);
    chk("R8 out high at load", out, 1);
    step(2); chk("R8 out high at 1", out, 1);
    step(1); chk("R8 pulse low at 0", out, 0);
    step(1); chk("R8 pulse one clock", out, 1);
    step(65535);
    chk("R8 count wrapped to 0", count, 0);
    chk("R8 no second pulse", out, 1);
  endtask

  task automatic t_mode5();
    do_reset(); gate = 1'b0;
    do_load(3'd5, 16'd3);
    chk("R9 out high at load", out, 1);
    step(1); chk("R9 counting", count, 2);
    gate = 1'b1; step(1);
    chk("R9 gate rise reload", count, 3);
    step(2); chk("R9 out high at 1", out, 1);
    step(1); chk("R9 pulse at 0", out, 0);
    step(1); chk("R9 pulse one clock", out, 1);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_zero();
    t_gate_hold();
    t_mode1();
    t_mode2();
    t_mode3_even();
    t_mode3_odd();
    t_mode4();
    t_mode5();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule